// File: doc/BRIEF.md
# Lockable Power-of-Two Watchdog Timer

This block supervises system software through a byte-wide host register port with two locations. A configuration byte selects the timeout as a four-bit logarithmic code. A control byte arms the timer. Once armed, the timer cannot be disarmed by any register write. Each further arming write restarts the countdown from the full period, and this restart serves as the keepalive.

Time is derived from the system clock. A prescaler divides the clock down to a base tick of one eighth of a second. Code k loads 2^k base ticks, so codes 0, 1 and 2 give 0.125 s, 0.25 s and 0.5 s, code 3 gives 1 s, and code 15 gives 4096 s. If the countdown runs out before software writes again, the block raises a one-cycle reset request and sets a sticky expired flag. It then reloads and keeps counting, so a missed service produces a periodic reset request until the system is reset.

Top module: `lockable_wdt`

## Requirements
- R1: After synchronous active-high reset the timer is stopped, the configuration byte reads 0x98 (code 8, 32 s), the status byte reads 0x80, and no reset request is raised while the timer is stopped.
- R2: A write to offset 0 is accepted only when its upper nibble is 0x9, and offset 0 then reads back the written byte. A write to offset 0 with any other upper nibble leaves the stored byte unchanged.
- R3: With code k, the first reset request appears exactly 2^k × (CLK_HZ/8) clock cycles after the clock edge that samples the arming write. The timeout code is bits 3:0 of the configuration byte.
- R4: Writing 0x81 to offset 1 starts the timer. Any other value written to offset 1 while the timer is stopped leaves it stopped.
- R5: While the timer is running, no write of any value to either offset stops it, and the pending expiry is unaffected by writes other than 0x81 to offset 1.
- R6: While the timer is running, each write of 0x81 to offset 1 reloads the full period of the current code, so that servicing more often than the period never raises a reset request.
- R7: A new code takes effect only at the next reload, whether that reload comes from a keepalive write or from an expiry. The countdown already in progress keeps its old length.
- R8: On expiry, reset_req is high for exactly one clock and the expired flag (status bit 1) is set. The timer stays running and reloads, and only a system reset clears the flag.
- R9: Offset 1 reads as bit 7 = 1, bit 1 = expired, bit 0 = running, and all other bits 0. The read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 1 | Register offset: 0 = configuration, 1 = control/status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the selected offset |
| reset_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions assume that the clock divider is at least two cycles per base tick, so that two expiries can never fall on adjacent cycles. They also assume that writes arrive as single-cycle strobes that are stable around the sampling edge. The stimulus drives every write at the falling edge for exactly one rising edge and runs the block with eight clocks per base tick. It uses only short codes, so each expected reset-request cycle can be predicted from the edge of the arming write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int          CODE_W    = 4;
  localparam logic [3:0]  CFG_TAG   = 4'h9;
  localparam logic [7:0]  ARM_BYTE  = 8'h81;
  localparam logic [7:0]  CFG_RESET = 8'h98;
  localparam logic        OFS_CFG   = 1'b0;
  localparam logic        OFS_CTL   = 1'b1;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = en && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  // Base ticks are at least DIV cycles apart (supports R3 timing)
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wr_data,
  input  logic              fire,
  output logic [7:0]        rd_data,
  output logic              running,
  output logic              kick,
  output logic [CODE_W-1:0] code
);
  logic [7:0] cfg_q;
  logic       run_q;
  logic       exp_q;
  logic       cfg_wr;

  assign cfg_wr  = wr_en && (addr == OFS_CFG) && (wr_data[7:4] == CFG_TAG);
  assign kick    = wr_en && (addr == OFS_CTL) && (wr_data == ARM_BYTE);
  assign running = run_q;
  assign code    = cfg_q[CODE_W-1:0];
  assign rd_data = (addr == OFS_CFG) ? cfg_q : {1'b1, 5'b0, exp_q, run_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= wr_data;
      if (kick)   run_q <= 1'b1;
      if (fire)   exp_q <= 1'b1;
    end
  end

  assert_bad_cfg_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CFG && wr_data[7:4] != CFG_TAG) |=> $stable(cfg_q));
  assert_run_locked_R5: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  assert_expired_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    exp_q |=> exp_q);
  assert_stay_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !kick) |=> !run_q);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int CNT_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              kick,
  input  logic [CODE_W-1:0] code,
  output logic              fire,
  output logic              reset_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  assign load = CNT_W'(1) << code;
  assign fire = run && tick && !kick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= fire;
      if (kick || fire)     cnt_q <= load;
      else if (run && tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  assert_quiet_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> !reset_req);
  assert_kick_defers_R6: assert property (@(posedge clk) disable iff (rst)
    kick |=> !reset_req);
  assert_count_live_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       reset_req
);
  localparam int DIV = CLK_HZ / 8;

  logic              running;
  logic              kick;
  logic              tick;
  logic              fire;
  logic [CODE_W-1:0] code;

  initial begin
    if (DIV < 2) $error("CLK_HZ must give at least two clocks per base tick");
  end

  wdt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .fire(fire), .rd_data(rd_data), .running(running), .kick(kick), .code(code)
  );

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .en(running), .clr(kick), .tick(tick)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst(rst), .run(running), .tick(tick), .kick(kick),
    .code(code), .fire(fire), .reset_req(reset_req)
  );

  // Reset request always coincides with a set expired flag in status
  assert_pulse_flags_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (u_regs.rd_data[1] || addr == OFS_CFG));
endmodule

// File: tb/test_lockable_wdt.sv
module test_lockable_wdt;
  localparam int CLK_HZ = 64;
  localparam int DIV    = CLK_HZ / 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       reset_req;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int mcode = 8;

  lockable_wdt #(.CLK_HZ(CLK_HZ)) i_lockable_wdt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .reset_req(reset_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each reset request with the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; fails++;
        $display("FAIL R3/R8 missing reset request: actual none expected cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (reset_req) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0] != cyc) begin
          fails++;
          $display("FAIL R3/R8 reset request: actual cycle %0d expected %0d", cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end else void'(exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d, output int edge_c);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    edge_c = cyc;
    wr_en = 1'b0;
    if (a == 1'b0 && d[7:4] == 4'h9) mcode = int'(d[3:0]);
  endtask

  // Driver: arming write, scoreboard refilled with eight periods
  task automatic kick(output int c0);
    wr(1'b1, 8'h81, c0);
    exp_q.delete();
    for (int i = 1; i <= 8; i++) exp_q.push_back(c0 + i * (1 << mcode) * DIV);
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s offset %0d: actual %02h expected %02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog timeout: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c;
    idle(4);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    rd_chk(1'b0, 8'h98, "R1");
    rd_chk(1'b1, 8'h80, "R1");
    checks++;
    if (reset_req !== 1'b0) begin
      fails++; $display("FAIL R1 reset_req: actual %b expected 0", reset_req);
    end
    idle(40);
    // R4: non-arming values leave it stopped
    wr(1'b1, 8'h80, c);
    wr(1'b1, 8'h01, c);
    rd_chk(1'b1, 8'h80, "R4");
    idle(40);
    // R2: configuration tag filter
    wr(1'b0, 8'hA1, c);
    rd_chk(1'b0, 8'h98, "R2");
    wr(1'b0, 8'h91, c);
    rd_chk(1'b0, 8'h91, "R2");
    // R3/R4/R8/R9: start with code 1, two expiries
    kick(c);
    rd_chk(1'b1, 8'h81, "R4_R9");
    idle(36);
    rd_chk(1'b1, 8'h83, "R8_R9");
    // R5: stop attempts ignored, expiries continue
    wr(1'b1, 8'h00, c);
    wr(1'b0, 8'h00, c);
    rd_chk(1'b1, 8'h83, "R5");
    idle(30);
    // R6: frequent service prevents expiry
    for (int i = 0; i < 10; i++) begin
      kick(c);
      idle(9);
    end
    idle(20);
    // R7: new code applies at next reload
    kick(c);
    idle(3);
    wr(1'b0, 8'h93, c);
    c = exp_q[0];
    exp_q.delete();
    exp_q.push_back(c);
    exp_q.push_back(c + 64);
    exp_q.push_back(c + 128);
    idle(100);
    // R3: shortest code
    wr(1'b0, 8'h90, c);
    kick(c);
    idle(20);
    // R1/R8: system reset clears state and flag
    @(negedge clk); rst = 1'b1;
    exp_q.delete();
    idle(2);
    @(negedge clk); rst = 1'b0;
    rd_chk(1'b1, 8'h80, "R1_R8");
    rd_chk(1'b0, 8'h98, "R1");
    idle(40);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule